// File: doc/BRIEF.md
# Desaturation Blanking and Fault Latch

This block guards a power switch against over-current, one switching period at a time. A PWM request asks for the gate to be on. The block passes that request to the gate command, watches a comparator flag that the surrounding logic has already synchronized, and cuts the gate short when the flag shows that the switch has left saturation.

Each gate-on interval starts with a leading-edge blanking window of `BLANK_CYCLES` clock cycles. During that window the sense node is held low through a pull-down enable, and the comparator is ignored. Once the window closes, the pull-down is released and the flag is sampled on every cycle for the rest of the on-time. A trip sets a fault latch. The latch forces the gate off for the remainder of that pulse and stays set until the next rising edge of the PWM request, which clears it and starts a fresh, fully blanked pulse. The fault output therefore ends single pulses and never shuts the switch down for good. If the sense input is stuck high, every pulse ends right after its blanking window. If it is stuck low, the block never trips.

Top module: `desat_guard`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `gate_on` is 0, `fault` is 0 and `sense_pd` is 1.
- R2: When no fault is latched, `gate_on` equals `pwm_req` delayed by one clock cycle. `gate_on` is never 1 unless `pwm_req` was 1 on the previous clock edge.
- R3: `sense_pd` is 1 whenever `gate_on` is 0, and during the first `BLANK_CYCLES` cycles of each gate-on interval. It is 0 only from cycle `BLANK_CYCLES` of the interval onward, counting the first on-cycle as cycle 0.
- R4: `desat_hi` has no effect while `sense_pd` is 1. It sets no fault and changes neither `gate_on` nor `sense_pd`.
- R5: If `desat_hi` is 1 on a clock edge while `gate_on` is 1 and `sense_pd` is 0, then from the next cycle `fault` is 1 and `gate_on` is 0.
- R6: Once set, `fault` stays 1, and `gate_on` stays 0, until `pwm_req` rises. This holds even if `desat_hi` drops, `pwm_req` stays high, or `pwm_req` goes low.
- R7: A clock edge that sees `pwm_req` at 1, after it was 0 on the previous edge, clears `fault` in the next cycle. In that same cycle `gate_on` turns on with a new blanking window.
- R8: A gate-on interval that ends early resets the blanking count. Even after a short pulse, the next interval gets the full `BLANK_CYCLES` of pull-down.
- R9: With `desat_hi` held at 1, every pulse of `pwm_req` longer than the window gives exactly `BLANK_CYCLES`+1 cycles of `gate_on`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_req | input | 1 | PWM request; 1 asks for the gate on |
| desat_hi | input | 1 | Synchronized comparator flag; 1 means the sense voltage is above the trip level |
| gate_on | output | 1 | Gate command to the output stage |
| sense_pd | output | 1 | Enable for the sense-node pull-down |
| fault | output | 1 | Latched desaturation fault for the current PWM period |

## Verification
`gate_on` follows a change of `pwm_req` one cycle later, and a trip sampled on one edge shows on `fault` and `gate_on` right after that edge. `sense_pd` drops `BLANK_CYCLES` cycles after the first on-cycle. A cycle-by-cycle model in the bench predicts all three outputs from the same sampled inputs. It is compared with the design at the falling edge, half a period after the register update. The directed checks count whole steps from the edge that samples a stimulus: they test the release of the pull-down after exactly `BLANK_CYCLES` and `BLANK_CYCLES`+1 steps, and they count the length of the on-pulse under a stuck-high flag.

// File: rtl/desat_guard_pkg.sv
package desat_guard_pkg;

  // Width of a counter that must hold the value n.
  function automatic int unsigned cnt_width(input int unsigned n);
    int unsigned w;
    w = 1;
    while ((1 << w) <= n) w++;
    return w;
  endfunction

  typedef enum logic [1:0] {
    PH_OFF     = 2'd0,
    PH_BLANK   = 2'd1,
    PH_WATCH   = 2'd2,
    PH_TRIPPED = 2'd3
  } guard_phase_e;

endpackage

// File: rtl/dsg_rise_detect.sv
module dsg_rise_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic level_q,
  output logic rise_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_i;
  end

  // Combinational: a high level now that was low on the last edge.
  assign rise_o = level_i & ~level_q;
endmodule

// File: rtl/dsg_blank_timer.sv
module dsg_blank_timer #(
  parameter int unsigned BLANK_CYCLES = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_on_i,
  output logic blank_done_o
);
  import desat_guard_pkg::*;

  localparam int unsigned W = cnt_width(BLANK_CYCLES);
  localparam logic [W-1:0] LAST = W'(BLANK_CYCLES);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!gate_on_i)      cnt_q <= '0;
    else if (cnt_q != LAST)   cnt_q <= cnt_q + 1'b1;
  end

  assign blank_done_o = gate_on_i && (cnt_q == LAST);
endmodule

// File: rtl/dsg_fault_latch.sv
module dsg_fault_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic fault_o
);
  // Clear wins: a new PWM period always starts unfaulted.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fault_o <= 1'b0;
    else if (clr_i)  fault_o <= 1'b0;
    else if (set_i)  fault_o <= 1'b1;
  end
endmodule

// File: rtl/desat_guard.sv
module desat_guard #(
  parameter int unsigned BLANK_CYCLES = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_req,
  input  logic desat_hi,
  output logic gate_on,
  output logic sense_pd,
  output logic fault
);
  import desat_guard_pkg::*;

  logic req_q, req_rise, blank_done, watching, trip;
  guard_phase_e phase;

  dsg_rise_detect u_rise (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (pwm_req),
    .level_q (req_q),
    .rise_o  (req_rise)
  );

  dsg_blank_timer #(.BLANK_CYCLES(BLANK_CYCLES)) u_blank (
    .clk          (clk),
    .rst_n        (rst_n),
    .gate_on_i    (gate_on),
    .blank_done_o (blank_done)
  );

  dsg_fault_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (trip),
    .clr_i   (req_rise),
    .fault_o (fault)
  );

  assign gate_on  = req_q & ~fault;
  assign watching = blank_done;
  assign trip     = watching & desat_hi;

  always_comb begin
    if (fault)         phase = PH_TRIPPED;
    else if (!gate_on) phase = PH_OFF;
    else if (watching) phase = PH_WATCH;
    else               phase = PH_BLANK;
  end

  // Pull-down released only while comparing.
  assign sense_pd = (phase != PH_WATCH);

  initial begin
    if (BLANK_CYCLES < 1) $error("BLANK_CYCLES must be at least 1");
  end
endmodule

// File: rtl/desat_guard_checker.sv
module desat_guard_checker (
  input logic clk,
  input logic rst_n,
  input logic pwm_req,
  input logic desat_hi,
  input logic gate_on,
  input logic sense_pd,
  input logic fault
);
  a_r3_pd_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_on |-> sense_pd);

  a_r2_gate_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    gate_on |-> $past(pwm_req));

  a_r5_trip_ends_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_on && !sense_pd && desat_hi) |=> (fault && !gate_on));

  a_r4_blank_no_trip: assert property (@(posedge clk) disable iff (!rst_n)
    (sense_pd && !fault) |=> !fault);

  a_r6_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (fault && !pwm_req) |=> fault);

  a_r6_fault_gates_off: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !gate_on);
endmodule

bind desat_guard desat_guard_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pwm_req  (pwm_req),
  .desat_hi (desat_hi),
  .gate_on  (gate_on),
  .sense_pd (sense_pd),
  .fault    (fault)
);

// File: tb/desat_guard_tb.sv
module desat_guard_tb;
  localparam int B = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_req = 1'b0;
  logic desat_hi = 1'b0;
  logic gate_on, sense_pd, fault;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  desat_guard #(.BLANK_CYCLES(B)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwm_req(pwm_req), .desat_hi(desat_hi),
    .gate_on(gate_on), .sense_pd(sense_pd), .fault(fault)
  );

  // Behavioural reference: remembers previous request, whether the gate
  // is on, how many on-cycles have elapsed, and the fault state.
  bit m_req_prev = 0, m_gate = 0, m_fault = 0;
  int m_on_cycles = 0;

  always @(posedge clk) begin
    bit rise, watching;
    if (!rst_n) begin
      m_req_prev = 0; m_gate = 0; m_fault = 0; m_on_cycles = 0;
    end else begin
      rise = pwm_req && !m_req_prev;
      watching = m_gate && (m_on_cycles >= B);
      if (rise) m_fault = 0;
      else if (watching && desat_hi) m_fault = 1;
      if (!m_gate) m_on_cycles = 0;
      else if (m_on_cycles < B) m_on_cycles++;
      m_req_prev = pwm_req;
      m_gate = m_req_prev && !m_fault;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 gate_on vs model", gate_on, m_gate);
      chk("R3 sense_pd vs model", sense_pd, !(m_gate && m_on_cycles >= B));
      chk("R5 fault vs model", fault, m_fault);
    end
  end

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    int on_count;
    step(3);
    chk("R1 gate_on in reset", gate_on, 1'b0);
    chk("R1 fault in reset", fault, 1'b0);
    chk("R1 sense_pd in reset", sense_pd, 1'b1);
    rst_n = 1'b1;
    step(1);
    chk("R1 gate_on after reset", gate_on, 1'b0);
    chk("R1 sense_pd after reset", sense_pd, 1'b1);

    // R4: comparator high only inside blanking is ignored
    pwm_req = 1; desat_hi = 1;
    step(1);
    chk("R2 gate on one cycle after request", gate_on, 1'b1);
    step(B - 1);
    desat_hi = 0;
    step(5);
    chk("R4 no fault from blanked flag", fault, 1'b0);
    chk("R4 gate still on", gate_on, 1'b1);
    pwm_req = 0;
    step(2);
    chk("R3 pull-down while off", sense_pd, 1'b1);

    // R4: flag high while gate off is ignored
    desat_hi = 1;
    step(4);
    chk("R4 no fault while off", fault, 1'b0);

    // R5 / R9: stuck-high flag ends the pulse after B+1 on-cycles
    pwm_req = 1;
    on_count = 0;
    for (int i = 0; i < 2 * B + 5; i++) begin
      step(1);
      if (gate_on) on_count++;
    end
    checks++;
    if (on_count != B + 1) begin
      fails++;
      $display("FAIL R9 on-cycles actual=%0d expected=%0d", on_count, B + 1);
    end
    chk("R5 fault after trip", fault, 1'b1);
    chk("R5 gate off after trip", gate_on, 1'b0);

    // R6: fault holds when flag drops and when request goes low
    desat_hi = 0;
    step(3);
    chk("R6 fault holds, request high", fault, 1'b1);
    chk("R6 gate held off", gate_on, 1'b0);
    pwm_req = 0;
    step(3);
    chk("R6 fault holds, request low", fault, 1'b1);

    // R7: new rising edge clears and re-arms
    pwm_req = 1;
    step(1);
    chk("R7 fault cleared on rise", fault, 1'b0);
    chk("R7 gate resumes", gate_on, 1'b1);
    chk("R7 new blanking window", sense_pd, 1'b1);
    step(B + 3);
    pwm_req = 0;
    step(2);

    // R8: short pulse then a fresh pulse gets full blanking
    pwm_req = 1;
    step(3);
    pwm_req = 0;
    step(1);
    pwm_req = 1;
    step(B);
    chk("R8 still blanked at last blank cycle", sense_pd, 1'b1);
    step(1);
    chk("R8 released after full window", sense_pd, 1'b0);
    pwm_req = 0;
    step(3);

    finish_run();
  end
endmodule